// File: doc/BRIEF.md
# Word-Lane Bridge: Partial-Word TX Packer and RX Unpacker

This block sits between a 32-bit register bus and a byte-serial engine. On the transmit side, software queues words by writing to one of four addresses. The address chosen sets how many bytes of the word are valid: all four, or one, two or three taken from the low lanes. A single bus write can therefore queue the short word that ends a transfer. Each queue entry keeps its data together with a 2-bit byte count. The serial side pulls exactly that many bytes, least significant first, through a valid/ready byte handshake.

On the receive side, bytes from the serial engine are collected into 32-bit words. A completed word enters a receive queue, and software reads the queue at a single address. When the serial engine signals the end of a transfer with one to three bytes still collected, the short word is pushed left-justified. Its valid bytes sit in the upper lanes and the lower lanes read zero, so a right shift by eight times the number of missing bytes recovers it. Both queue depths come from one parameter.

Two ordering and capacity errors are reported as one-cycle pulses:
- A short transmit word is only accepted when the transmit queue is empty. If full words are still queued, the short word is refused, because it could otherwise leave in the wrong order.
- A write to a full queue is dropped.

Top module: `word_lane_bridge`

## Requirements
- R1: A bus write to address 0x1C queues all four bytes of the write data. The serial side emits them least significant byte first: bits 7:0, then 15:8, 23:16 and 31:24.
- R2: Bus writes to 0x80, 0x84 and 0x88 queue 1, 2 and 3 bytes respectively. The bytes are taken from the low lanes of the write data, and the upper write-data bits never reach the serial side.
- R3: A write to 0x80, 0x84 or 0x88 while tx_empty is low is discarded. tx_order_err pulses high in the cycle after that write. The bytes already queued are emitted unchanged, and nothing is added to them.
- R4: A write to 0x1C while the transmit queue holds DEPTH entries is discarded. tx_ovf pulses high in the cycle after that write.
- R5: Queue entries leave in write order. A byte transfers on a clock edge where ser_tx_valid and ser_tx_ready are both high. While ser_tx_valid is high and ser_tx_ready is low, ser_tx_valid and ser_tx_byte hold.
- R6: After four received bytes, a word is queued with the first byte in bits 7:0 and the fourth in bits 31:24.
- R7: ser_rx_end with n (1 to 3) bytes collected queues a word. The k-th byte (k from 0) sits in bits 8*(4-n+k)+7 down to 8*(4-n+k), and the lower lanes are zero. ser_rx_end may coincide with the last byte. ser_rx_end with no byte collected queues nothing.
- R8: A read at address 0x20 returns the oldest received word on bus_rd_data in the cycle after bus_rd_en, and removes the word from the queue. A read when the receive queue is empty returns zero. rx_avail is high exactly when the receive queue holds a word.
- R9: A received word completed while the receive queue holds DEPTH words is discarded. rx_ovf pulses high in the cycle after.
- R10: After reset, ser_tx_valid, rx_avail, tx_ovf, tx_order_err, rx_ovf and bus_rd_data are zero, and tx_empty is one.
- R11: Bus writes to other addresses queue nothing. Reads at other addresses return zero and remove nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Bus write strobe |
| bus_wr_addr | input | ADDR_W | Bus write address |
| bus_wr_data | input | 32 | Bus write data |
| bus_rd_en | input | 1 | Bus read strobe |
| bus_rd_addr | input | ADDR_W | Bus read address |
| bus_rd_data | output | 32 | Read data, valid the cycle after bus_rd_en |
| tx_empty | output | 1 | Transmit queue holds no entry |
| tx_ovf | output | 1 | Pulse: full-word write dropped on a full queue |
| tx_order_err | output | 1 | Pulse: short-word write refused on a non-empty queue |
| ser_tx_valid | output | 1 | Transmit byte available |
| ser_tx_byte | output | 8 | Transmit byte |
| ser_tx_ready | input | 1 | Serial engine takes the byte |
| ser_rx_valid | input | 1 | Received byte strobe |
| ser_rx_byte | input | 8 | Received byte |
| ser_rx_end | input | 1 | End-of-transfer strobe |
| rx_avail | output | 1 | Receive queue holds a word |
| rx_ovf | output | 1 | Pulse: received word dropped on a full queue |

## Verification
The hardest case to reach is a refused short write. It needs full words still sitting in the transmit queue at the moment the short write arrives, while the serial side has not drained them. The bench holds ser_tx_ready low, queues a full word, then writes a short one and expects the refusal pulse. It then releases ready and checks, through its byte scoreboard, that exactly the four earlier bytes come out. The same stall fills the queue to its depth for the overflow case. A receive-side flood of DEPTH+1 words without reads provokes the receive drop.

// File: rtl/wlb_pkg.sv
package wlb_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned BYTE_W = 8;

  // 0 encodes four valid bytes, 1..3 encode that many
  typedef logic [1:0] lane_cnt_t;

  typedef struct packed {
    logic [WORD_W-1:0] data;
    lane_cnt_t         cnt;
  } tx_entry_t;

  // index of the last byte lane an entry uses
  function automatic logic [1:0] last_lane(input lane_cnt_t c);
    return (c == 2'd0) ? 2'd3 : c - 2'd1;
  endfunction

  function automatic logic [BYTE_W-1:0] lane_pick(input logic [WORD_W-1:0] w,
                                                  input logic [1:0] idx);
    return w[{idx, 3'b000} +: BYTE_W];
  endfunction

  // newest byte enters the top lane, older bytes move down
  function automatic logic [WORD_W-1:0] shift_in(input logic [WORD_W-1:0] acc,
                                                 input logic [BYTE_W-1:0] b);
    return {b, acc[WORD_W-1:BYTE_W]};
  endfunction
endpackage

// File: rtl/wlb_fifo.sv
module wlb_fifo #(
  parameter int W     = 34,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [PW:0]  wp, rp;

  assign empty = (wp == rp);
  assign full  = (wp[PW] != rp[PW]) && (wp[PW-1:0] == rp[PW-1:0]);
  assign rdata = mem[rp[PW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp[PW-1:0]] <= wdata;
  end

  // R4
  fifo_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full));
  // R8
  fifo_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop && empty));
endmodule

// File: rtl/wlb_tx_serializer.sv
module wlb_tx_serializer
  import wlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  tx_entry_t         head_i,
  input  logic              empty_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              pop_o
);
  logic [1:0] idx_q;
  logic       fire;

  assign valid_o = !empty_i;
  assign byte_o  = lane_pick(head_i.data, idx_q);
  assign fire    = valid_o && ready_i;
  assign pop_o   = fire && (idx_q == last_lane(head_i.cnt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx_q <= 2'd0;
    else if (pop_o) idx_q <= 2'd0;
    else if (fire)  idx_q <= idx_q + 2'd1;
  end

  // R5
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(byte_o)));
  // R2
  lane_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (idx_q <= last_lane(head_i.cnt)));
endmodule

// File: rtl/wlb_rx_assembler.sv
module wlb_rx_assembler
  import wlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              end_i,
  output logic              push_o,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] acc_q, nxt_acc;
  logic [2:0]        cnt_q, nxt_cnt;

  always_comb begin
    nxt_acc = acc_q;
    nxt_cnt = cnt_q;
    if (byte_valid_i) begin
      nxt_acc = shift_in(acc_q, byte_i);
      nxt_cnt = cnt_q + 3'd1;
    end
    push_o = (nxt_cnt == 3'd4) || (end_i && (nxt_cnt != 3'd0));
    word_o = nxt_acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (push_o) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= nxt_acc;
      cnt_q <= nxt_cnt;
    end
  end

  // R6
  word_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid_i && cnt_q == 3'd3) |=> (cnt_q == 3'd0));
  // R7
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (end_i && !byte_valid_i && cnt_q != 3'd0) |=> (cnt_q == 3'd0 && acc_q == '0));
endmodule

// File: rtl/word_lane_bridge.sv
module word_lane_bridge
  import wlb_pkg::*;
#(
  parameter int DEPTH        = 8,
  parameter int ADDR_W       = 8,
  parameter int TX_FULL_ADDR = 'h1C,
  parameter int TX_PART_BASE = 'h80,
  parameter int RX_ADDR      = 'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_wr_addr,
  input  logic [31:0]       bus_wr_data,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_rd_addr,
  output logic [31:0]       bus_rd_data,
  output logic              tx_empty,
  output logic              tx_ovf,
  output logic              tx_order_err,
  output logic              ser_tx_valid,
  output logic [7:0]        ser_tx_byte,
  input  logic              ser_tx_ready,
  input  logic              ser_rx_valid,
  input  logic [7:0]        ser_rx_byte,
  input  logic              ser_rx_end,
  output logic              rx_avail,
  output logic              rx_ovf
);
  localparam int ENTRY_W = $bits(tx_entry_t);

  // write decode
  logic      wr_hit, wr_full, wr_partial;
  lane_cnt_t wr_cnt;

  always_comb begin
    wr_hit = 1'b0;
    wr_cnt = 2'd0;
    if (bus_wr_en) begin
      if (bus_wr_addr == ADDR_W'(TX_FULL_ADDR)) wr_hit = 1'b1;
      for (int k = 1; k < 4; k++) begin
        if (bus_wr_addr == ADDR_W'(TX_PART_BASE + 4 * (k - 1))) begin
          wr_hit = 1'b1;
          wr_cnt = lane_cnt_t'(k);
        end
      end
    end
  end

  assign wr_full    = wr_hit && (wr_cnt == 2'd0);
  assign wr_partial = wr_hit && (wr_cnt != 2'd0);

  // transmit path
  logic      tx_full, tx_empty_w, tx_push, tx_pop;
  tx_entry_t tx_in, tx_head;

  assign tx_in   = '{data: bus_wr_data, cnt: wr_cnt};
  assign tx_push = (wr_full && !tx_full) || (wr_partial && tx_empty_w);

  wlb_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(tx_push), .wdata(tx_in), .pop(tx_pop),
    .rdata(tx_head), .full(tx_full), .empty(tx_empty_w)
  );

  wlb_tx_serializer u_tx_ser (
    .clk(clk), .rst_n(rst_n),
    .head_i(tx_head), .empty_i(tx_empty_w), .ready_i(ser_tx_ready),
    .valid_o(ser_tx_valid), .byte_o(ser_tx_byte), .pop_o(tx_pop)
  );

  assign tx_empty = tx_empty_w;

  // receive path
  logic        asm_push, rx_full, rx_empty, rx_pop, rd_hit;
  logic [31:0] asm_word, rx_head;

  wlb_rx_assembler u_rx_asm (
    .clk(clk), .rst_n(rst_n),
    .byte_valid_i(ser_rx_valid), .byte_i(ser_rx_byte), .end_i(ser_rx_end),
    .push_o(asm_push), .word_o(asm_word)
  );

  wlb_fifo #(.W(32), .DEPTH(DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(asm_push && !rx_full), .wdata(asm_word), .pop(rx_pop),
    .rdata(rx_head), .full(rx_full), .empty(rx_empty)
  );

  assign rd_hit   = bus_rd_en && (bus_rd_addr == ADDR_W'(RX_ADDR));
  assign rx_pop   = rd_hit && !rx_empty;
  assign rx_avail = !rx_empty;

  // registered read data and event pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rd_data  <= '0;
      tx_ovf       <= 1'b0;
      tx_order_err <= 1'b0;
      rx_ovf       <= 1'b0;
    end else begin
      bus_rd_data  <= rx_pop ? rx_head : 32'd0;
      tx_ovf       <= wr_full && tx_full;
      tx_order_err <= wr_partial && !tx_empty_w;
      rx_ovf       <= asm_push && rx_full;
    end
  end

  // R3
  order_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_partial && !tx_empty) |=> (tx_order_err && !tx_ovf));
  // R4
  tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_full && tx_full) |=> tx_ovf);
  // R8
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !rx_avail) |=> (bus_rd_data == 32'd0));
  // R9
  rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (asm_push && rx_full) |=> rx_ovf);
endmodule

// File: tb/word_lane_bridge_tb.sv
module word_lane_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [7:0]  bus_wr_addr = '0, bus_rd_addr = '0;
  logic [31:0] bus_wr_data = '0, bus_rd_data;
  logic        tx_empty, tx_ovf, tx_order_err, ser_tx_valid;
  logic [7:0]  ser_tx_byte;
  logic        ser_tx_ready = 1'b0;
  logic        ser_rx_valid = 1'b0, ser_rx_end = 1'b0;
  logic [7:0]  ser_rx_byte = '0;
  logic        rx_avail, rx_ovf;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0]  txq[$];
  logic [31:0] rxq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  word_lane_bridge #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .bus_wr_en(bus_wr_en), .bus_wr_addr(bus_wr_addr), .bus_wr_data(bus_wr_data),
    .bus_rd_en(bus_rd_en), .bus_rd_addr(bus_rd_addr), .bus_rd_data(bus_rd_data),
    .tx_empty(tx_empty), .tx_ovf(tx_ovf), .tx_order_err(tx_order_err),
    .ser_tx_valid(ser_tx_valid), .ser_tx_byte(ser_tx_byte), .ser_tx_ready(ser_tx_ready),
    .ser_rx_valid(ser_rx_valid), .ser_rx_byte(ser_rx_byte), .ser_rx_end(ser_rx_end),
    .rx_avail(rx_avail), .rx_ovf(rx_ovf)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // monitor: compares every transmitted byte with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (rst_n === 1'b1 && ser_tx_valid && ser_tx_ready) begin
        if (txq.size() == 0) begin
          check(1'b0, "R5 byte with nothing queued", {24'd0, ser_tx_byte}, 32'd0);
        end else begin
          automatic logic [7:0] exp_b = txq.pop_front();
          check(ser_tx_byte == exp_b, "R1/R2/R5 serial byte",
                {24'd0, ser_tx_byte}, {24'd0, exp_b});
        end
      end
    end
  end

  // mode: 0 accepted, 1 order refusal, 2 overflow, 3 ignored address
  task automatic tx_write(input logic [7:0] addr, input logic [31:0] data, input int mode);
    int n;
    @(negedge clk);
    bus_wr_en   = 1'b1;
    bus_wr_addr = addr;
    bus_wr_data = data;
    n = (addr == 8'h1C) ? 4 : ((int'(addr) - 'h80) / 4 + 1);
    if (mode == 0)
      for (int k = 0; k < n; k++) txq.push_back(data[8*k +: 8]);
    @(negedge clk);
    bus_wr_en = 1'b0;
    check(tx_order_err == (mode == 1), "R3 order pulse", {31'd0, tx_order_err}, {31'd0, mode == 1});
    check(tx_ovf == (mode == 2), "R4 overflow pulse", {31'd0, tx_ovf}, {31'd0, mode == 2});
  endtask

  task automatic wait_tx_drained(input string req);
    while (!tx_empty) @(negedge clk);
    @(negedge clk);
    check(txq.size() == 0, req, txq.size(), 0);
  endtask

  // end_mode: 0 no end strobe, 1 end in its own cycle, 2 end with last byte
  task automatic rx_send(input logic [31:0] v, input int n, input int end_mode);
    logic [31:0] exp;
    bit          drop;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ser_rx_valid = 1'b1;
      ser_rx_byte  = v[8*k +: 8];
      ser_rx_end   = (end_mode == 2) && (k == n - 1);
    end
    if (end_mode == 1) begin
      @(negedge clk);
      ser_rx_valid = 1'b0;
      ser_rx_end   = 1'b1;
    end
    @(negedge clk);
    ser_rx_valid = 1'b0;
    ser_rx_end   = 1'b0;
    if (n == 4 || (n > 0 && end_mode != 0)) begin
      exp = 32'd0;
      for (int k = 0; k < n; k++) exp[8*(4-n+k) +: 8] = v[8*k +: 8];
      drop = (rxq.size() == DEPTH);
      check(rx_ovf == drop, "R9 receive drop pulse", {31'd0, rx_ovf}, {31'd0, drop});
      if (!drop) rxq.push_back(exp);
    end else begin
      check(rx_ovf == 1'b0, "R7 no word on empty end", {31'd0, rx_ovf}, 32'd0);
    end
  endtask

  task automatic rx_read(input logic [7:0] addr, input string req);
    logic [31:0] exp;
    @(negedge clk);
    bus_rd_en   = 1'b1;
    bus_rd_addr = addr;
    @(negedge clk);
    bus_rd_en = 1'b0;
    exp = (addr == 8'h20 && rxq.size() != 0) ? rxq.pop_front() : 32'd0;
    check(bus_rd_data == exp, req, bus_rd_data, exp);
    check(rx_avail == (rxq.size() != 0), "R8 rx_avail level",
          {31'd0, rx_avail}, {31'd0, rxq.size() != 0});
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10
    check(ser_tx_valid == 1'b0, "R10 tx valid", {31'd0, ser_tx_valid}, 0);
    check(tx_empty == 1'b1, "R10 tx empty", {31'd0, tx_empty}, 1);
    check(rx_avail == 1'b0, "R10 rx avail", {31'd0, rx_avail}, 0);
    check({tx_ovf, tx_order_err, rx_ovf} == 3'b000, "R10 flags",
          {29'd0, tx_ovf, tx_order_err, rx_ovf}, 0);
    check(bus_rd_data == 32'd0, "R10 read data", bus_rd_data, 0);

    // R1 / R2: full and short words, short ones after the queue drains
    ser_tx_ready = 1'b1;
    tx_write(8'h1C, 32'h44332211, 0);
    tx_write(8'h1C, 32'hDDCCBBAA, 0);
    wait_tx_drained("R1 full words drained");
    tx_write(8'h80, 32'hFFFFFF5A, 0);
    wait_tx_drained("R2 one byte drained");
    tx_write(8'h84, 32'hEEEEB2B1, 0);
    wait_tx_drained("R2 two bytes drained");
    tx_write(8'h88, 32'h99C3C2C1, 0);
    wait_tx_drained("R2 three bytes drained");

    // R3: short write refused while a full word waits
    ser_tx_ready = 1'b0;
    tx_write(8'h1C, 32'h0A0B0C0D, 0);
    tx_write(8'h84, 32'h00007777, 1);
    tx_write(8'h88, 32'h00666666, 1);
    ser_tx_ready = 1'b1;
    wait_tx_drained("R3 only earlier bytes emitted");

    // R4: fill to depth, then one more
    ser_tx_ready = 1'b0;
    for (int i = 0; i < DEPTH; i++) tx_write(8'h1C, 32'h10203040 + i * 32'h01010101, 0);
    tx_write(8'h1C, 32'hBADBAD00, 2);
    repeat (3) @(negedge clk);
    ser_tx_ready = 1'b1;
    wait_tx_drained("R4 depth words drained in order");

    // R11: other addresses queue nothing
    tx_write(8'h24, 32'h12345678, 3);
    tx_write(8'h8C, 32'h12345678, 3);
    repeat (2) @(negedge clk);
    check(ser_tx_valid == 1'b0, "R11 stray write ignored", {31'd0, ser_tx_valid}, 0);

    // R5: alternating stalls across a mixed stream
    ser_tx_ready = 1'b0;
    tx_write(8'h1C, 32'h87654321, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      ser_tx_ready = i[0];
    end
    ser_tx_ready = 1'b1;
    wait_tx_drained("R5 stalled stream drained");

    // R6 / R7 / R8: receive side
    rx_read(8'h20, "R8 empty read is zero");
    rx_send(32'hA4A3A2A1, 4, 0);
    rx_read(8'h20, "R6 full word");
    rx_send(32'h000000B1, 1, 1);
    rx_send(32'h0000C2C1, 2, 1);
    rx_send(32'h00D3D2D1, 3, 2);
    rx_read(8'h20, "R7 one byte left-justified");
    rx_read(8'h20, "R7 two bytes left-justified");
    rx_read(8'h20, "R7 three bytes with end on last byte");
    rx_send(32'h0, 0, 1);
    rx_read(8'h20, "R7 end with nothing collected");
    rx_send(32'h5E5F6061, 4, 2);
    rx_read(8'h24, "R11 stray read returns zero");
    rx_read(8'h20, "R11 word kept after stray read");

    // R9: flood the receive queue
    for (int i = 0; i < DEPTH + 1; i++) rx_send(32'hC0000000 + i, 4, 0);
    for (int i = 0; i < DEPTH + 1; i++) rx_read(8'h20, "R9 receive words after drop");

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule